// File: doc/BRIEF.md
# Multichannel SPI ADC Scan Sequencer

This block is the host side of an SPI link to a pipelined 16-bit analog-to-digital converter. After reset it sends two setup frames on its own. The first is a settings write that selects the wide input range. The second is a pin-configuration word that leaves every auxiliary pin as an input. The block then waits for a trigger.

On a trigger it latches the channel-enable mask and sends one conversion command for each enabled channel, lowest index first. It then appends two all-zero frames. The converter answers each command two frames late, so these extra frames are needed to collect the last results. Every answer that belongs to a channel command is handed out as a one-cycle beat carrying the sample and the channel that was requested. The beat is flagged when the channel tag returned by the converter disagrees with the request.

A scan ends with a one-cycle done pulse. A trigger that arrives while the block is not idle does not start a scan. Instead it sets a sticky overrun flag, which only reset clears.

Top module: `spi_adc_scanner`

## Requirements
- R1: During and right after reset the chip select is high, the serial clock is low, no beat is valid and the overrun flag is clear. The first frame sent after reset is the settings word 0x1840: the manual bit 12, the write-enable bit 11 and the range bit 6 are set.
- R2: The second frame after reset is the pin-configuration word 0x4000: bit 14 is set and every other bit is zero.
- R3: For each channel set in the latched mask, one command frame 0x1000 | (channel << 7) is sent, with the channel in bits 10:7, in ascending channel order.
- R4: The last channel command is followed by exactly two 0x0000 frames, so a scan of p channels takes p+2 frames. An all-zero mask sends no frame at all.
- R5: The answer in frame k+2 belongs to the command in frame k. Exactly one beat is produced per enabled channel, in ascending order, tagged with the requested channel. The answers in the first two frames of a scan produce no beat.
- R6: The beat data is the SAMPLE_BITS-wide field of the answer word whose most significant bit is bit 11 and whose least significant bit is bit 12-SAMPLE_BITS.
- R7: The tag-error flag is high on a beat exactly when answer bits 15:12 differ from the requested channel.
- R8: Frames are 16 bits long and sent MSB first. The serial clock idles low and has a period of CLK_DIV system clocks. MOSI changes after the falling edge and MISO is captured on the rising edge. Chip select stays high for at least one clock between frames.
- R9: scanDone pulses for one cycle. For a non-empty mask it comes one cycle after the last beat. For an empty mask it comes one cycle after the trigger was sampled.
- R10: A trigger sampled while the block is not idle is ignored: it adds no frame and no beat. It sets the overrun flag, which stays set until reset. A trigger accepted while idle leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chanMask | input | NUM_CH | Channel-enable mask, latched on an accepted trigger |
| trigger | input | 1 | Starts a scan when sampled high while idle |
| spiMiso | input | 1 | Serial data from the converter |
| spiSclk | output | 1 | Serial clock, idles low |
| spiCsN | output | 1 | Active-low chip select, released between frames |
| spiMosi | output | 1 | Serial command data to the converter |
| sampleValid | output | 1 | One-cycle beat strobe |
| sampleData | output | SAMPLE_BITS | Extracted sample |
| sampleCh | output | 4 | Channel requested for this beat |
| sampleTagErr | output | 1 | Returned tag differs from the requested channel |
| scanDone | output | 1 | One-cycle end-of-scan pulse |
| overrun | output | 1 | Sticky flag for a trigger that was ignored |

## Verification
Every one of the sixteen masks of the four-channel configuration is scanned. This covers empty, single, sparse and full masks, and shows that command order, frame count and beat count follow the mask rather than a fixed count. Each scan returns sample values that depend on both the channel and the scan number, so a beat paired with the wrong frame of the two-frame pipeline, or carried over from a previous scan, is caught.

One scan is made with the converter model returning a wrong tag on a single channel. This separates a flag raised on that beat alone from one that is stuck or raised on the wrong beat. A trigger issued in the middle of a scan, followed by a reset, shows the trigger being dropped, the overrun flag holding, and the setup frames being replayed after reset.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int FRAME_BITS = 16;
  localparam int TAG_W      = 4;
  localparam int TAG_LSB    = 12;
  localparam int CH_LSB     = 7;

  localparam logic [FRAME_BITS-1:0] CFG_WORD   = 16'h1840;
  localparam logic [FRAME_BITS-1:0] PINCFG_WORD = 16'h4000;
  localparam logic [FRAME_BITS-1:0] FLUSH_WORD = 16'h0000;

  typedef struct packed {
    logic                  startFrame;
    logic [FRAME_BITS-1:0] txWord;
  } ctrlStrobe_t;

  typedef struct packed {
    logic             valid;
    logic [TAG_W-1:0] ch;
  } slotInfo_t;

  typedef enum logic [2:0] {
    ST_BOOT, ST_CFG, ST_PINCFG, ST_IDLE, ST_CHAN, ST_FLUSH_A, ST_FLUSH_B
  } seqState_t;

  function automatic logic [FRAME_BITS-1:0] chanCmd(input logic [TAG_W-1:0] ch);
    logic [FRAME_BITS-1:0] w;
    w = '0;
    w[TAG_LSB] = 1'b1;
    w[CH_LSB +: TAG_W] = ch;
    return w;
  endfunction
endpackage

// File: rtl/adcseq_datapath.sv
module adcseq_datapath
  import adcseq_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int SAMPLE_BITS = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  ctrlStrobe_t            strobe,
  input  logic                   miso,
  output logic                   sclk,
  output logic                   csN,
  output logic                   mosi,
  output logic                   frameDone,
  output logic                   active,
  output logic [TAG_W-1:0]       rxTag,
  output logic [SAMPLE_BITS-1:0] sampleData
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BIT_W = $clog2(FRAME_BITS);

  logic [DIV_W-1:0]      divCnt;
  logic [BIT_W-1:0]      bitCnt;
  logic [FRAME_BITS-1:0] txShift;
  logic [FRAME_BITS-1:0] rxShift;
  logic [FRAME_BITS-1:0] rxWord;
  logic                  halfTick;

  assign halfTick   = (divCnt == DIV_W'(HALF - 1));
  assign mosi       = txShift[FRAME_BITS-1];
  assign rxTag      = rxWord[TAG_LSB +: TAG_W];
  assign sampleData = rxWord[TAG_LSB-1 -: SAMPLE_BITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt    <= '0;
      bitCnt    <= '0;
      txShift   <= '0;
      rxShift   <= '0;
      rxWord    <= '0;
      sclk      <= 1'b0;
      csN       <= 1'b1;
      active    <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      if (strobe.startFrame) begin
        active  <= 1'b1;
        csN     <= 1'b0;
        sclk    <= 1'b0;
        txShift <= strobe.txWord;
        bitCnt  <= '0;
        divCnt  <= '0;
      end else if (active) begin
        if (halfTick) begin
          divCnt <= '0;
          if (!sclk) begin
            sclk    <= 1'b1;
            rxShift <= {rxShift[FRAME_BITS-2:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bitCnt == BIT_W'(FRAME_BITS - 1)) begin
              active    <= 1'b0;
              csN       <= 1'b1;
              frameDone <= 1'b1;
              rxWord    <= rxShift;
            end else begin
              bitCnt  <= bitCnt + 1'b1;
              txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) csN |-> !sclk); // R8
  AST_CS_GAP: assert property (@(posedge clk) disable iff (rst) $rose(csN) |=> csN); // R8
  AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (rst) frameDone |-> (csN && !active)); // R8
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] chanMask,
  input  logic              trigger,
  input  logic              frameDone,
  input  logic              dpActive,
  input  logic [TAG_W-1:0]  rxTag,
  output ctrlStrobe_t       strobe,
  output logic              sampleValid,
  output logic [TAG_W-1:0]  sampleCh,
  output logic              tagError,
  output logic              scanDone,
  output logic              overrun
);
  seqState_t         state;
  logic [NUM_CH-1:0] remMask;
  logic [NUM_CH-1:0] pickSrc;
  logic [NUM_CH-1:0] pickRest;
  logic [TAG_W-1:0]  pickCh;
  slotInfo_t         curSlot;
  slotInfo_t         pipeA;
  slotInfo_t         pipeB;

  always_comb begin
    pickSrc = (state == ST_IDLE) ? chanMask : remMask;
    pickCh  = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pickSrc[i]) pickCh = TAG_W'(i);
    end
    pickRest = pickSrc & ~(NUM_CH'(1) << pickCh);
  end

  assign sampleValid = frameDone && pipeB.valid;
  assign sampleCh    = pipeB.ch;
  assign tagError    = sampleValid && (rxTag != pipeB.ch);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_BOOT;
      strobe   <= '0;
      remMask  <= '0;
      curSlot  <= '0;
      pipeA    <= '0;
      pipeB    <= '0;
      scanDone <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      strobe.startFrame <= 1'b0;
      scanDone          <= 1'b0;
      if (trigger && state != ST_IDLE) overrun <= 1'b1;
      if (frameDone) begin
        pipeB <= pipeA;
        pipeA <= curSlot;
      end
      case (state)
        ST_BOOT: begin
          strobe  <= '{startFrame: 1'b1, txWord: CFG_WORD};
          curSlot <= '0;
          state   <= ST_CFG;
        end
        ST_CFG: if (frameDone) begin
          strobe <= '{startFrame: 1'b1, txWord: PINCFG_WORD};
          state  <= ST_PINCFG;
        end
        ST_PINCFG: if (frameDone) state <= ST_IDLE;
        ST_IDLE: if (trigger) begin
          if (chanMask == '0) begin
            scanDone <= 1'b1;
          end else begin
            strobe  <= '{startFrame: 1'b1, txWord: chanCmd(pickCh)};
            curSlot <= '{valid: 1'b1, ch: pickCh};
            remMask <= pickRest;
            state   <= ST_CHAN;
          end
        end
        ST_CHAN: if (frameDone) begin
          if (remMask != '0) begin
            strobe  <= '{startFrame: 1'b1, txWord: chanCmd(pickCh)};
            curSlot <= '{valid: 1'b1, ch: pickCh};
            remMask <= pickRest;
          end else begin
            strobe  <= '{startFrame: 1'b1, txWord: FLUSH_WORD};
            curSlot <= '0;
            state   <= ST_FLUSH_A;
          end
        end
        ST_FLUSH_A: if (frameDone) begin
          strobe <= '{startFrame: 1'b1, txWord: FLUSH_WORD};
          state  <= ST_FLUSH_B;
        end
        ST_FLUSH_B: if (frameDone) begin
          scanDone <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_BOOT;
      endcase
    end
  end

  AST_START_WHEN_QUIET: assert property (@(posedge clk) disable iff (rst) strobe.startFrame |-> !dpActive); // R8
  AST_BEAT_IN_SCAN: assert property (@(posedge clk) disable iff (rst) sampleValid |-> (state != ST_IDLE && state != ST_PINCFG)); // R5
  AST_BEAT_CH_RANGE: assert property (@(posedge clk) disable iff (rst) sampleValid |-> ({1'b0, sampleCh} < 5'(NUM_CH))); // R5
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst) scanDone |-> !dpActive); // R9
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst) overrun |=> overrun); // R10
endmodule

// File: rtl/spi_adc_scanner.sv
module spi_adc_scanner
  import adcseq_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SAMPLE_BITS = 12,
  parameter int CLK_DIV     = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_CH-1:0]      chanMask,
  input  logic                   trigger,
  input  logic                   spiMiso,
  output logic                   spiSclk,
  output logic                   spiCsN,
  output logic                   spiMosi,
  output logic                   sampleValid,
  output logic [SAMPLE_BITS-1:0] sampleData,
  output logic [3:0]             sampleCh,
  output logic                   sampleTagErr,
  output logic                   scanDone,
  output logic                   overrun
);
  ctrlStrobe_t      strobe;
  logic             frameDone;
  logic             dpActive;
  logic [TAG_W-1:0] rxTag;

  adcseq_ctrl #(.NUM_CH(NUM_CH)) ctrl_i (
    .clk(clk), .rst(rst), .chanMask(chanMask), .trigger(trigger),
    .frameDone(frameDone), .dpActive(dpActive), .rxTag(rxTag),
    .strobe(strobe), .sampleValid(sampleValid), .sampleCh(sampleCh),
    .tagError(sampleTagErr), .scanDone(scanDone), .overrun(overrun)
  );

  adcseq_datapath #(.CLK_DIV(CLK_DIV), .SAMPLE_BITS(SAMPLE_BITS)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .miso(spiMiso),
    .sclk(spiSclk), .csN(spiCsN), .mosi(spiMosi), .frameDone(frameDone),
    .active(dpActive), .rxTag(rxTag), .sampleData(sampleData)
  );
endmodule

// File: tb/spi_adc_scanner_tb_top.sv
module spi_adc_scanner_tb_top;
  localparam int NCH = 4;
  localparam int SB  = 12;
  localparam int DIV = 4;

  logic clk = 0;
  logic rst = 1;
  logic [NCH-1:0] chanMask = '0;
  logic trigger = 0;
  logic misoR = 0;
  logic spiSclk, spiCsN, spiMosi, sampleValid, sampleTagErr, scanDone, overrun;
  logic [SB-1:0] sampleData;
  logic [3:0] sampleCh;

  always #4 clk = ~clk;

  spi_adc_scanner #(.NUM_CH(NCH), .SAMPLE_BITS(SB), .CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .chanMask(chanMask), .trigger(trigger), .spiMiso(misoR),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi), .sampleValid(sampleValid),
    .sampleData(sampleData), .sampleCh(sampleCh), .sampleTagErr(sampleTagErr),
    .scanDone(scanDone), .overrun(overrun)
  );

  int checkCnt = 0;
  int failCnt = 0;
  bit finished = 0;
  int scanNo = 0;
  int corruptCh = 15;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] sampleVal(input int ch, input int s);
    return 12'((ch * 291 + s * 37 + 5) & 12'hFFF);
  endfunction

  // converter model: answer in frame n follows the command of frame n-2
  logic [15:0] cmdLog [0:511];
  int frameCnt = 0;
  logic [15:0] rxSh = '0;
  logic [15:0] txResp = '0;
  int bitIdx = 0;
  int sclkRises = 0;
  int protoErrs = 0;
  realtime lastRise = 0;
  realtime csHighAt = 0;

  function automatic logic [15:0] respFor(input int n);
    logic [15:0] c;
    logic [3:0] ch, tag;
    if (n < 2) return 16'h0;
    c = cmdLog[n-2];
    if (c[12] && !c[11] && !c[14]) begin
      ch = c[10:7];
      tag = (int'(ch) == corruptCh) ? (ch ^ 4'h1) : ch;
      return {tag, sampleVal(int'(ch), scanNo)};
    end
    return 16'h0;
  endfunction

  always @(negedge spiCsN) begin
    if ($realtime - csHighAt < 8.0) protoErrs++;
    txResp = respFor(frameCnt);
    bitIdx = 0;
    sclkRises = 0;
    misoR = txResp[15];
  end
  always @(negedge spiSclk) begin
    if (!spiCsN) begin
      bitIdx++;
      if (bitIdx < 16) misoR = txResp[15-bitIdx];
    end
  end
  always @(posedge spiSclk) begin
    if (sclkRises > 0 && ($realtime - lastRise) != DIV * 8.0) protoErrs++;
    lastRise = $realtime;
    sclkRises++;
    rxSh = {rxSh[14:0], spiMosi};
  end
  always @(posedge spiCsN) begin
    csHighAt = $realtime;
    if (sclkRises == 16) begin
      cmdLog[frameCnt] = rxSh;
      frameCnt++;
    end
    sclkRises = 0;
  end

  // beat monitor, sampled at the falling clock edge
  int cyc = 0;
  int nBeats = 0;
  int beatCh [0:15];
  int beatData [0:15];
  int beatErr [0:15];
  int lastBeatCyc = 0;
  int doneCyc = 0;
  int trigCyc = 0;
  bit doneSeen = 0;

  always @(negedge clk) begin
    cyc++;
    if (trigger) trigCyc = cyc;
    if (sampleValid) begin
      if (nBeats < 16) begin
        beatCh[nBeats] = int'(sampleCh);
        beatData[nBeats] = int'(sampleData);
        beatErr[nBeats] = int'(sampleTagErr);
      end
      nBeats++;
      lastBeatCyc = cyc;
    end
    if (scanDone) begin
      doneSeen = 1;
      doneCyc = cyc;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulseTrigger();
    tick(1);
    trigger = 1;
    tick(1);
    trigger = 0;
  endtask

  task automatic waitInit(input int base);
    int to = 0;
    while (frameCnt < base + 2 && to < 2000) begin tick(1); to++; end
    tick(4);
    check(frameCnt == base + 2, "R1 setup frame count", frameCnt - base, 2);
    check(cmdLog[base] == 16'h1840, "R1 settings word", int'(cmdLog[base]), 16'h1840);
    check(cmdLog[base+1] == 16'h4000, "R2 pin-config word", int'(cmdLog[base+1]), 16'h4000);
  endtask

  task automatic runScan(input logic [NCH-1:0] mask);
    int f0, p, k, to;
    scanNo++;
    f0 = frameCnt;
    p = $countones(mask);
    nBeats = 0;
    doneSeen = 0;
    chanMask = mask;
    pulseTrigger();
    to = 0;
    while (!doneSeen && to < 3000) begin tick(1); to++; end
    tick(3);
    check(doneSeen, "R9 done pulse seen", int'(doneSeen), 1);
    check(nBeats == p, "R5 beat count", nBeats, p);
    check(frameCnt - f0 == ((p == 0) ? 0 : p + 2), "R4 frame count", frameCnt - f0, (p == 0) ? 0 : p + 2);
    k = 0;
    for (int ch = 0; ch < NCH; ch++) begin
      if (mask[ch]) begin
        check(cmdLog[f0+k] == (16'h1000 | 16'(ch << 7)), "R3 channel command", int'(cmdLog[f0+k]), 16'h1000 | (ch << 7));
        if (k < nBeats) begin
          check(beatCh[k] == ch, "R5 beat channel", beatCh[k], ch);
          check(beatData[k] == int'(sampleVal(ch, scanNo)), "R6 sample data", beatData[k], int'(sampleVal(ch, scanNo)));
          check(beatErr[k] == int'(ch == corruptCh), "R7 tag error flag", beatErr[k], int'(ch == corruptCh));
        end
        k++;
      end
    end
    if (p > 0) begin
      check(cmdLog[f0+p] == 16'h0 && cmdLog[f0+p+1] == 16'h0, "R4 flush frames",
            int'({cmdLog[f0+p], cmdLog[f0+p+1]}), 0);
      check(doneCyc == lastBeatCyc + 1, "R9 done after last beat", doneCyc - lastBeatCyc, 1);
    end else begin
      check(doneCyc == trigCyc + 1, "R9 done for empty mask", doneCyc - trigCyc, 1);
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checkCnt, failCnt);
  endtask

  initial begin
    int f0;
    tick(3);
    check(spiCsN == 1 && spiSclk == 0, "R1 SPI idle in reset", int'({spiCsN, spiSclk}), 2);
    check(sampleValid == 0 && overrun == 0, "R1 outputs clear in reset", int'({sampleValid, overrun}), 0);
    rst = 0;
    tick(1);
    check(overrun == 0 && sampleValid == 0, "R1 outputs clear after reset", int'({sampleValid, overrun}), 0);
    waitInit(0);

    for (int m = 0; m < 16; m++) runScan(NCH'(m));
    check(overrun == 0, "R10 idle triggers leave overrun clear", int'(overrun), 0);

    corruptCh = 2;
    runScan(4'hF);
    corruptCh = 15;

    // trigger in the middle of a scan
    scanNo++;
    f0 = frameCnt;
    nBeats = 0;
    doneSeen = 0;
    chanMask = 4'hF;
    pulseTrigger();
    tick(150);
    pulseTrigger();
    tick(1);
    check(overrun == 1, "R10 overrun set by busy trigger", int'(overrun), 1);
    tick(1200);
    check(doneSeen, "R10 first scan completes", int'(doneSeen), 1);
    check(nBeats == 4, "R10 ignored trigger adds no beat", nBeats, 4);
    check(frameCnt - f0 == 6, "R10 ignored trigger adds no frame", frameCnt - f0, 6);
    check(overrun == 1, "R10 overrun sticky", int'(overrun), 1);

    check(protoErrs == 0, "R8 sclk period and chip-select gap", protoErrs, 0);

    rst = 1;
    tick(3);
    check(overrun == 0 && spiCsN == 1, "R1 reset clears overrun", int'({overrun, spiCsN}), 1);
    f0 = frameCnt;
    rst = 0;
    waitInit(f0);
    runScan(4'b1010);

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      summary();
      $finish;
    end
  end
endmodule